// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns serial audio into parallel samples. Each sample is a two's-complement word sent MSB first. A bit clock and a word/frame clock arrive with the data. Both are sampled in the system clock domain: a capture edge is detected when the bit clock changes between two system clock cycles. At most three data pins are used. In the stereo formats each pin carries one left/right pair. In the two packed multichannel formats, all six channels share pin 0.

A 3-bit format code picks one of six framings. Each framing sets which frame-clock level means left, how many bit clocks the MSB trails the frame edge, whether the word is right-aligned to the end of a 32-bit half frame, and, for the packed formats, the slot layout. A 2-bit width code selects 16, 20 or 24 valid bits. A finished word is left-aligned into a 24-bit output and the unused low bits are zero. With each word the block gives a one-cycle valid strobe and a channel index.

Top module: `audio_rx`

## Requirements
- R1: After reset, every valid strobe and data output is 0. No strobe is issued until the first frame edge has been seen.
- R2: Format 000 (I2S) uses a bit-clock rising-edge capture. A low frame clock means left. The MSB is one bit clock after the frame-clock transition. Lane k reports channel 2k for left and 2k+1 for right.
- R3: Format 011 (left-justified) treats a high frame clock as left. The MSB is on the first bit clock after the transition. Capture is on the rising edge.
- R4: Format 001 (right-justified) treats a high frame clock as left. The LSB is on bit 31, the last bit clock of each 32-bit half frame, so the MSB sits at bit 32−width.
- R5: Format 010 (DSP) starts a word at each rising frame sync, with the MSB on the next bit clock. Capture is on the bit-clock falling edge. Left and right cannot be told apart, so lane k always reports channel 2k.
- R6: Format 100 (packed, 256 bits) starts a frame at the falling frame clock. The frame has eight 32-bit slots on lane 0. The MSB is at offset 1 of a slot. Slots 0–2 are channels 0, 2, 4. Slots 3 and 7 are blank. Slots 4–6 are channels 1, 3, 5. Lanes 1 and 2 issue no strobes.
- R7: Format 101 (packed, 128 bits) starts a frame at the rising frame clock. Lane 0 carries three 20-bit slots at bits 0, 20 and 40 (channels 0, 2, 4). Bits 60–63 are blank. Three more slots sit at bits 64, 84 and 104 (channels 1, 3, 5). The MSB is at offset 0 of a slot. A width code of 24 bits is clamped to 20.
- R8: Width codes are 00 = 24, 01 = 20 and 10 = 16 bits. Code 11 acts as 24. A narrower word is placed in the top bits of the 24-bit output and the rest is zero-filled.
- R9: Formats 110 and 111 produce no valid strobe on any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word select / frame sync |
| sdin | input | LANES | Serial data pins |
| mode | input | 3 | Framing format code |
| wordWidth | input | 2 | Word width code |
| validOut | output | LANES | One-cycle strobe per lane |
| dataOut | output | LANES*24 | Left-aligned sample per lane |
| chanOut | output | LANES*3 | Channel index per lane |

## Verification
Every format is driven with whole frames of per-frame random words. Bits outside any data window are filled with ones. A word that is shifted by one bit, or taken from the wrong window, therefore shows up as a data mismatch rather than passing unnoticed. Runs of one format at different width codes separate the MSB offset (I2S, DSP, packed 256) from a right-aligned LSB (right-justified) and from zero-filling. The two packed formats check the slot-to-channel order and the blank slots. A 24-bit request in the 128-bit layout checks the clamp. Each run opens with a short preamble held at the frame clock's idle level. Any strobe before the first true frame edge, or any strobe in the two silent formats, is reported as unexpected.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int CH_W       = 3;
  localparam int HALF_BITS  = 32;
  localparam int PK256_SLOT = 32;
  localparam int PK128_SLOT = 20;
  localparam int PK128_HALF = 64;
  localparam int CNT_W      = $clog2(8 * PK256_SLOT);
  localparam int SLOT_W     = $clog2(PK256_SLOT);

  typedef enum logic [2:0] {
    FMT_I2S   = 3'b000,
    FMT_RJ    = 3'b001,
    FMT_DSP   = 3'b010,
    FMT_LJ    = 3'b011,
    FMT_PK256 = 3'b100,
    FMT_PK128 = 3'b101,
    FMT_AUX   = 3'b110,
    FMT_RSVD  = 3'b111
  } fmt_e;

  typedef struct packed {
    logic            shiftEn;
    logic            emit;
    logic            packedMode;
    logic            rightSide;
    logic [CH_W-1:0] slotChan;
    logic [1:0]      widthSel;
  } strobe_t;
endpackage

// File: rtl/audio_rx_ctrl.sv
module audio_rx_ctrl
  import audio_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclk,
  input  logic    lrclk,
  input  logic [2:0] mode,
  input  logic [1:0] wordWidth,
  output strobe_t stb
);
  fmt_e fmt;
  assign fmt = fmt_e'(mode);

  logic bclkQ, lrPrev, lrKnown, synced;
  logic [CNT_W-1:0] bitCnt, pos, wEff, wM1;
  logic capEdge, frameEdge, hit, rightSide, isPacked;
  logic [1:0] effSel;
  logic [CH_W-1:0] slotChan;
  logic [CNT_W-SLOT_W-1:0] slot;

  // Capture edge: falling for DSP framing, rising otherwise
  assign capEdge = (fmt == FMT_DSP) ? (bclkQ & ~bclk) : (bclk & ~bclkQ);
  assign isPacked = (fmt == FMT_PK256) || (fmt == FMT_PK128);

  always_comb begin
    unique case (fmt)
      FMT_I2S, FMT_LJ, FMT_RJ: frameEdge = lrKnown && (lrclk != lrPrev);
      FMT_DSP, FMT_PK128:      frameEdge = lrKnown && lrclk && !lrPrev;
      FMT_PK256:               frameEdge = lrKnown && !lrclk && lrPrev;
      default:                 frameEdge = 1'b0;
    endcase
  end

  assign pos = frameEdge ? '0 : ((bitCnt == '1) ? bitCnt : bitCnt + CNT_W'(1));

  // Effective width: 128-bit packing caps at 20, code 11 acts as 24
  always_comb begin
    effSel = wordWidth;
    if (wordWidth == 2'b11) effSel = 2'b00;
    if (fmt == FMT_PK128 && effSel == 2'b00) effSel = 2'b01;
  end

  always_comb begin
    unique case (effSel)
      2'b01:   wEff = CNT_W'(20);
      2'b10:   wEff = CNT_W'(16);
      default: wEff = CNT_W'(24);
    endcase
  end
  assign wM1  = wEff - CNT_W'(1);
  assign slot = pos[CNT_W-1:SLOT_W];

  always_comb begin
    hit       = 1'b0;
    slotChan  = '0;
    rightSide = 1'b0;
    unique case (fmt)
      FMT_I2S: begin hit = (pos == wEff); rightSide = lrclk; end
      FMT_LJ:  begin hit = (pos == wM1);  rightSide = !lrclk; end
      FMT_RJ:  begin hit = (pos == CNT_W'(HALF_BITS - 1)); rightSide = !lrclk; end
      FMT_DSP: hit = (pos == wEff);
      FMT_PK256: begin
        hit = (pos[SLOT_W-1:0] == wEff[SLOT_W-1:0]) && (slot[1:0] != 2'b11);
        slotChan = {slot[1:0], slot[2]};
      end
      FMT_PK128: begin
        for (int k = 0; k < 3; k++) begin
          if (pos == CNT_W'(k * PK128_SLOT) + wM1) begin
            hit = 1'b1;
            slotChan = CH_W'(2 * k);
          end
          if (pos == CNT_W'(PK128_HALF + k * PK128_SLOT) + wM1) begin
            hit = 1'b1;
            slotChan = CH_W'(2 * k + 1);
          end
        end
      end
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ   <= 1'b0;
      lrPrev  <= 1'b0;
      lrKnown <= 1'b0;
      synced  <= 1'b0;
      bitCnt  <= '0;
    end else begin
      bclkQ <= bclk;
      if (capEdge) begin
        lrPrev  <= lrclk;
        lrKnown <= 1'b1;
        bitCnt  <= pos;
        if (frameEdge) synced <= 1'b1;
      end
    end
  end

  always_comb begin
    stb.shiftEn    = capEdge;
    stb.emit       = capEdge && synced && hit;
    stb.packedMode = isPacked;
    stb.rightSide  = rightSide;
    stb.slotChan   = slotChan;
    stb.widthSel   = effSel;
  end
endmodule

// File: rtl/audio_rx_datapath.sv
module audio_rx_datapath
  import audio_rx_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int DATA_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES-1:0]        sdin,
  input  strobe_t                 stb,
  output logic [LANES-1:0]        validOut,
  output logic [LANES*DATA_W-1:0] dataOut,
  output logic [LANES*CH_W-1:0]   chanOut
);
  function automatic logic [DATA_W-1:0] alignWord(input logic [DATA_W-1:0] raw,
                                                  input logic [1:0] sel);
    unique case (sel)
      2'b01:   return raw << (DATA_W - 20);
      2'b10:   return raw << (DATA_W - 16);
      default: return raw;
    endcase
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IS_LANE0 = (i == 0);
    logic [DATA_W-1:0] shReg, shNext, wordQ;
    logic [CH_W-1:0]   chanQ;
    logic              validQ, laneOn;

    assign shNext = {shReg[DATA_W-2:0], sdin[i]};
    assign laneOn = stb.emit && (IS_LANE0 || !stb.packedMode);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg  <= '0;
        wordQ  <= '0;
        chanQ  <= '0;
        validQ <= 1'b0;
      end else begin
        if (stb.shiftEn) shReg <= shNext;
        validQ <= laneOn;
        if (laneOn) begin
          wordQ <= alignWord(shNext, stb.widthSel);
          chanQ <= stb.packedMode ? stb.slotChan
                                  : CH_W'(2 * i) + CH_W'(stb.rightSide);
        end
      end
    end

    assign validOut[i]                 = validQ;
    assign dataOut[i*DATA_W +: DATA_W] = wordQ;
    assign chanOut[i*CH_W +: CH_W]     = chanQ;
  end
endmodule

// File: rtl/audio_rx.sv
module audio_rx
  import audio_rx_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int DATA_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    bclk,
  input  logic                    lrclk,
  input  logic [LANES-1:0]        sdin,
  input  logic [2:0]              mode,
  input  logic [1:0]              wordWidth,
  output logic [LANES-1:0]        validOut,
  output logic [LANES*DATA_W-1:0] dataOut,
  output logic [LANES*CH_W-1:0]   chanOut
);
  strobe_t stb;

  audio_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bclk(bclk), .lrclk(lrclk),
    .mode(mode), .wordWidth(wordWidth), .stb(stb)
  );

  audio_rx_datapath #(.LANES(LANES), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .sdin(sdin), .stb(stb),
    .validOut(validOut), .dataOut(dataOut), .chanOut(chanOut)
  );
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk
  import audio_rx_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int DATA_W = 24
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2:0]              mode,
  input logic [1:0]              wordWidth,
  input logic [LANES-1:0]        validOut,
  input logic [LANES*DATA_W-1:0] dataOut,
  input logic [LANES*CH_W-1:0]   chanOut
);
  // R9
  silent_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2:1] == 2'b11) |=> (validOut == '0));

  // R6
  packed_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2:1] == 2'b10) |=> (validOut[LANES-1:1] == '0));

  // R5
  dsp_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b010) |=> (!validOut[0] || chanOut[CH_W-1:0] == '0));

  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordWidth == 2'b10 && mode != 3'b101) |=> (!validOut[0] || dataOut[DATA_W-17:0] == '0));

  // R7
  pk128_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b101) |=> (!validOut[0] || dataOut[DATA_W-21:0] == '0));

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut[0] |=> !validOut[0]);
endmodule

bind audio_rx audio_rx_chk #(.LANES(LANES), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .wordWidth(wordWidth),
  .validOut(validOut), .dataOut(dataOut), .chanOut(chanOut)
);

// File: tb/audio_rx_tb_top.sv
module audio_rx_tb_top;
  localparam int LANES = 3;
  localparam int DW    = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0;
  logic [LANES-1:0] sdin = '0;
  logic [2:0] mode = 3'b000;
  logic [1:0] wordWidth = 2'b00;
  logic [LANES-1:0] validOut;
  logic [LANES*DW-1:0] dataOut;
  logic [LANES*3-1:0] chanOut;

  int checks = 0;
  int fails = 0;
  int unexpected = 0;
  string curTag = "R1";

  int expLane[$];
  int expChan[$];
  logic [23:0] expData[$];
  string expTag[$];

  logic [23:0] wv [6];

  always #4 clk = ~clk;

  audio_rx #(.LANES(LANES), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .bclk(bclk), .lrclk(lrclk), .sdin(sdin),
    .mode(mode), .wordWidth(wordWidth),
    .validOut(validOut), .dataOut(dataOut), .chanOut(chanOut)
  );

  // Returns {lrclk, data bit} for a bit position of a frame
  function automatic logic [1:0] frameBit(input int f, input int w, input int b, input int lane);
    int half, off, p0, ch, slot, l, k;
    logic lr, d;
    half = b / 32; off = b % 32; d = 1'b1; lr = 1'b0;
    case (f)
      0, 1, 3: begin
        lr = (f == 0) ? half[0] : !half[0];
        p0 = (f == 0) ? 1 : (f == 3) ? 0 : 32 - w;
        ch = 2 * lane + half;
        if (off >= p0 && off < p0 + w) d = wv[ch][23 - (off - p0)];
      end
      2: begin
        lr = (off == 0);
        ch = 2 * lane + half;
        if (off >= 1 && off <= w) d = wv[ch][24 - off];
      end
      4: begin
        slot = b / 32;
        lr = (slot >= 4);
        if (lane == 0 && slot != 3 && slot != 7 && off >= 1 && off <= w) begin
          ch = (slot < 3) ? 2 * slot : 2 * (slot - 4) + 1;
          d = wv[ch][24 - off];
        end
      end
      5: begin
        lr = (b < 64);
        half = (b >= 64) ? 1 : 0;
        l = b - 64 * half;
        k = l / 20; off = l % 20;
        if (lane == 0 && l < 60 && off < w) d = wv[2 * k + half][23 - off];
      end
      default: lr = half[0];
    endcase
    return {lr, d};
  endfunction

  function automatic logic [23:0] topBits(input logic [23:0] v, input int w);
    logic [23:0] m;
    m = 24'hFFFFFF << (24 - w);
    return v & m;
  endfunction

  task automatic pushExp(input int lane, input int ch, input logic [23:0] d, input string tag);
    expLane.push_back(lane);
    expChan.push_back(ch);
    expData.push_back(d);
    expTag.push_back(tag);
  endtask

  task automatic sendBit(input logic lrv, input logic [LANES-1:0] d, input logic dsp);
    @(negedge clk);
    bclk = dsp; lrclk = lrv; sdin = d;
    repeat (2) @(negedge clk);
    bclk = !dsp;
    @(negedge clk);
  endtask

  task automatic runCase(input int f, input logic [1:0] wsel, input string tag);
    int w, flen, startUnexp;
    logic [1:0] fb;
    logic [LANES-1:0] d;
    logic lrv;
    curTag = tag;
    @(negedge clk);
    rstN = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdin = '0;
    mode = 3'(f); wordWidth = wsel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    w = (wsel == 2'b01) ? 20 : (wsel == 2'b10) ? 16 : 24;
    if (f == 5 && w > 20) w = 20;
    flen = (f == 4) ? 256 : (f == 5) ? 128 : 64;
    startUnexp = unexpected;
    for (int i = 0; i < 6; i++) wv[i] = 24'h0;
    fb = frameBit(f, w, flen - 1, 0);
    for (int p = 0; p < 2; p++) sendBit(fb[1], '1, f == 2);
    for (int fr = 0; fr < 2; fr++) begin
      for (int i = 0; i < 6; i++) wv[i] = 24'($urandom);
      if (f <= 3) begin
        for (int h = 0; h < 2; h++)
          for (int ln = 0; ln < LANES; ln++)
            pushExp(ln, (f == 2) ? 2 * ln : 2 * ln + h, topBits(wv[2 * ln + h], w), tag);
      end else if (f <= 5) begin
        pushExp(0, 0, topBits(wv[0], w), tag);
        pushExp(0, 2, topBits(wv[2], w), tag);
        pushExp(0, 4, topBits(wv[4], w), tag);
        pushExp(0, 1, topBits(wv[1], w), tag);
        pushExp(0, 3, topBits(wv[3], w), tag);
        pushExp(0, 5, topBits(wv[5], w), tag);
      end
      for (int b = 0; b < flen; b++) begin
        lrv = 1'b0;
        for (int ln = 0; ln < LANES; ln++) begin
          fb = frameBit(f, w, b, ln);
          d[ln] = fb[0];
          lrv = fb[1];
        end
        sendBit(lrv, d, f == 2);
      end
    end
    repeat (20) @(negedge clk);
    checks++;
    if (expLane.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected samples never produced (actual %0d, expected 0)",
               tag, expLane.size(), expLane.size());
      expLane.delete(); expChan.delete(); expData.delete(); expTag.delete();
    end
    if (f >= 6) begin
      checks++;
      if (unexpected != startUnexp) begin
        fails++;
        $display("FAIL R9: strobes in silent format %0d (actual %0d, expected 0)",
                 f, unexpected - startUnexp);
      end
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        for (int ln = 0; ln < LANES; ln++) begin
          if (validOut[ln]) begin
            if (expLane.size() == 0) begin
              unexpected++;
              if (curTag != "R9") begin
                checks++; fails++;
                $display("FAIL %s: unexpected strobe lane %0d chan %0d data %h (expected none)",
                         curTag, ln, chanOut[ln*3 +: 3], dataOut[ln*DW +: DW]);
              end
            end else begin
              int el, ec;
              logic [23:0] ed;
              string et;
              el = expLane.pop_front(); ec = expChan.pop_front();
              ed = expData.pop_front(); et = expTag.pop_front();
              checks++;
              if (el != ln || ec != int'(chanOut[ln*3 +: 3]) || ed != dataOut[ln*DW +: DW]) begin
                fails++;
                $display("FAIL %s: lane/chan/data actual %0d/%0d/%h expected %0d/%0d/%h",
                         et, ln, chanOut[ln*3 +: 3], dataOut[ln*DW +: DW], el, ec, ed);
              end
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (validOut != '0 || dataOut != '0) begin
      fails++;
      $display("FAIL R1: after reset valid %b data %h (expected 0/0)", validOut, dataOut);
    end
    runCase(0, 2'b00, "R2");
    runCase(3, 2'b00, "R3");
    runCase(1, 2'b00, "R4");
    runCase(2, 2'b00, "R5");
    runCase(4, 2'b00, "R6");
    runCase(5, 2'b01, "R7");
    runCase(5, 2'b00, "R7");
    runCase(3, 2'b01, "R8");
    runCase(1, 2'b10, "R8");
    runCase(0, 2'b10, "R8");
    runCase(2, 2'b01, "R8");
    runCase(4, 2'b10, "R8");
    runCase(0, 2'b11, "R8");
    runCase(6, 2'b00, "R9");
    runCase(7, 2'b00, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule